// File: doc/BRIEF.md
# Double-Buffered 8-Bit PWM Channel

This block produces one pulse-width-modulated pin level from two software values: a duty value `n` and a prescale value `m`. A count-source enable sets the base rate. A prescale counter divides that rate by `m+1`. Each divided step advances a period counter that runs from 0 to 254, so one period lasts 255 steps. The output is high while the step count is below `n`. A duty of 00h therefore gives a fully low period, and FFh gives a fully high one.

Software writes do not reach the comparison logic directly. Each write lands in a staging register. The staged values are copied into the working registers only on the final tick of a period, so a period never changes shape partway through. A small controller with three states governs the run enable:

- `ST_OFF` (reset state): counters cleared, output frozen.
- `ST_REPLAY`: the first period after enabling, which runs on the working values held from before the stop.
- `ST_RUN`: normal operation.

The transitions are:

- `ST_OFF`→`ST_REPLAY` on `run_en`=1.
- `ST_REPLAY`→`ST_RUN` at the end of a period.
- `ST_REPLAY`/`ST_RUN`→`ST_OFF` on `run_en`=0.

A route select chooses between the PWM level and a plain software data bit for the pin.

Top module: `pwm8_gen`

## Requirements
- R1: A synchronous active-high reset clears both staging registers and both working registers to 00h, clears both counters, and enters `ST_OFF`. With `pin_sel`=1 the pin is then low.
- R2: While running, one period lasts 255×(m+1) count-source ticks. Only cycles with `tick_en`=1 advance the counters, so a held-low `tick_en` freezes the output level.
- R3: Within a period the pin is high for the first n×(m+1) ticks and low for the rest, with at most one high-to-low change.
- R4: A working duty of 00h keeps the pin low for the whole period. A working duty of FFh keeps it high for the whole period.
- R5: `wr_duty`=1 loads `wr_data` into the duty staging register, and `wr_pre`=1 loads it into the prescale staging register. The working registers take the staged values only on the last tick of a period. A write made partway through a period first shows in the following period.
- R6: When `run_en` falls, the pin keeps the level of the last running cycle for as long as the block stays disabled.
- R7: On re-enable the counters restart from zero. The first period uses the working values from before the stop, and values written while stopped apply from the second period.
- R8: With `pin_sel`=0 the pin follows `gpio_bit`. With `pin_sel`=1 it carries the PWM level.
- R9: The controller follows exactly the transitions `ST_OFF`→`ST_REPLAY` (enable), `ST_REPLAY`→`ST_RUN` (period end), and any running state→`ST_OFF` (`run_en`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count-source enable, one base tick per high cycle |
| wr_duty | input | 1 | Write strobe for the duty staging register |
| wr_pre | input | 1 | Write strobe for the prescale staging register |
| wr_data | input | 8 | Write data |
| run_en | input | 1 | Run enable |
| pin_sel | input | 1 | 1 routes PWM to the pin, 0 routes `gpio_bit` |
| gpio_bit | input | 1 | Software data bit for general-purpose use |
| pwm_pin | output | 1 | Pin level |

## Verification
The pin is combinational from registered counters, so the level for step k appears in the cycle that follows the k-th clock edge after the enabling edge. The bench therefore drives `run_en` on a falling edge and takes the next 255×(m+1) falling-edge samples as exactly one period. Staged writes are checked one whole period later, because the copy into the working registers happens on the final tick. The frozen level after a stop is checked from the first sample after the disabling edge. Routing changes on `pin_sel` and `gpio_bit` take effect within the same cycle and are sampled one half-cycle later.

// File: rtl/pwm8_pkg.sv
package pwm8_pkg;
    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_REPLAY = 2'd1,
        ST_RUN    = 2'd2
    } pwm_state_e;
endpackage

// File: rtl/pwm8_regs.sv
// Staging and working registers for duty and prescale values.
module pwm8_regs #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_duty,
    input  logic         wr_pre,
    input  logic [W-1:0] wr_data,
    input  logic         load,
    output logic [W-1:0] duty_lat,
    output logic [W-1:0] pre_lat
);
    logic [W-1:0] duty_stage;
    logic [W-1:0] pre_stage;

    always_ff @(posedge clk) begin
        if (rst) begin
            duty_stage <= '0;
            pre_stage  <= '0;
        end else begin
            if (wr_duty) duty_stage <= wr_data;
            if (wr_pre)  pre_stage  <= wr_data;
        end
    end

    // Copy happens on the final tick of a period; a write in the same
    // cycle is staged and moves across one period later.
    always_ff @(posedge clk) begin
        if (rst) begin
            duty_lat <= '0;
            pre_lat  <= '0;
        end else if (load) begin
            duty_lat <= duty_stage;
            pre_lat  <= pre_stage;
        end
    end
endmodule

// File: rtl/pwm8_timebase.sv
// Prescale divider and period step counter.
module pwm8_timebase #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         tick_en,
    input  logic [W-1:0] pre_lat,
    output logic [W-1:0] pre_cnt,
    output logic [W-1:0] per_cnt,
    output logic         period_end
);
    localparam logic [W-1:0] LAST_STEP = W'((1 << W) - 2);

    logic step;

    always_comb begin
        step       = tick_en && !clear && (pre_cnt == pre_lat);
        period_end = step && (per_cnt == LAST_STEP);
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            pre_cnt <= '0;
            per_cnt <= '0;
        end else if (tick_en) begin
            if (step) begin
                pre_cnt <= '0;
                per_cnt <= period_end ? '0 : per_cnt + 1'b1;
            end else begin
                pre_cnt <= pre_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pwm8_fsm.sv
// Run control: off, replay of the first period, steady run.
module pwm8_fsm
    import pwm8_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run_en,
    input  logic       period_end,
    output pwm_state_e st_q,
    output logic       active
);
    pwm_state_e st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_OFF:    st_d = run_en ? ST_REPLAY : ST_OFF;
            ST_REPLAY: st_d = !run_en ? ST_OFF : (period_end ? ST_RUN : ST_REPLAY);
            ST_RUN:    st_d = run_en ? ST_RUN : ST_OFF;
            default:   st_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_OFF;
        else     st_q <= st_d;
    end

    always_comb begin
        active = (st_q != ST_OFF);
    end
endmodule

// File: rtl/pwm8_gen.sv
// Top level: one PWM channel with double-buffered duty and prescale.
module pwm8_gen
    import pwm8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick_en,
    input  logic         wr_duty,
    input  logic         wr_pre,
    input  logic [W-1:0] wr_data,
    input  logic         run_en,
    input  logic         pin_sel,
    input  logic         gpio_bit,
    output logic         pwm_pin
);
    logic [W-1:0] duty_lat;
    logic [W-1:0] pre_lat;
    logic [W-1:0] pre_cnt;
    logic [W-1:0] per_cnt;
    logic         period_end;
    logic         active;
    logic         lvl;
    logic         hold_q;
    pwm_state_e   st_q;

    pwm8_regs #(.W(W)) regs_i (
        .clk(clk), .rst(rst), .wr_duty(wr_duty), .wr_pre(wr_pre),
        .wr_data(wr_data), .load(period_end),
        .duty_lat(duty_lat), .pre_lat(pre_lat)
    );

    pwm8_timebase #(.W(W)) tb_i (
        .clk(clk), .rst(rst), .clear(!active), .tick_en(tick_en),
        .pre_lat(pre_lat), .pre_cnt(pre_cnt), .per_cnt(per_cnt),
        .period_end(period_end)
    );

    pwm8_fsm fsm_i (
        .clk(clk), .rst(rst), .run_en(run_en), .period_end(period_end),
        .st_q(st_q), .active(active)
    );

    // All-ones duty exceeds the largest step index, so it stays high.
    always_comb lvl = (per_cnt < duty_lat);

    // Remember the level of the last running cycle for the frozen state.
    always_ff @(posedge clk) begin
        if (rst)         hold_q <= 1'b0;
        else if (active) hold_q <= lvl;
    end

    always_comb begin
        if (!pin_sel)    pwm_pin = gpio_bit;
        else if (active) pwm_pin = lvl;
        else             pwm_pin = hold_q;
    end
endmodule

// File: rtl/pwm8_chk.sv
module pwm8_chk
    import pwm8_pkg::*;
#(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         run_en,
    input logic         pin_sel,
    input logic         pwm_pin,
    input pwm_state_e   st_q,
    input logic         period_end,
    input logic [W-1:0] duty_lat,
    input logic [W-1:0] pre_lat,
    input logic [W-1:0] pre_cnt,
    input logic [W-1:0] per_cnt
);
    // R6
    frozen_pin_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_OFF && pin_sel) ##1 (st_q == ST_OFF && pin_sel) |-> $stable(pwm_pin));

    // R5
    duty_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !period_end |=> $stable(duty_lat));

    // R5
    pre_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !period_end |=> $stable(pre_lat));

    // R2
    step_range_chk: assert property (@(posedge clk) disable iff (rst)
        per_cnt <= W'((1 << W) - 2));

    // R2
    prescale_range_chk: assert property (@(posedge clk) disable iff (rst)
        pre_cnt <= pre_lat);

    // R4
    full_high_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q != ST_OFF && pin_sel && duty_lat == '1) |-> pwm_pin);

    // R4
    full_low_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q != ST_OFF && pin_sel && duty_lat == '0) |-> !pwm_pin);

    // R9
    start_replay_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_OFF && run_en) |=> st_q == ST_REPLAY);

    // R9
    replay_done_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_REPLAY && run_en && period_end) |=> st_q == ST_RUN);

    // R9
    stop_chk: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> st_q == ST_OFF);
endmodule

bind pwm8_gen pwm8_chk #(.W(W)) chk_i (
    .clk(clk), .rst(rst), .run_en(run_en), .pin_sel(pin_sel),
    .pwm_pin(pwm_pin), .st_q(st_q), .period_end(period_end),
    .duty_lat(duty_lat), .pre_lat(pre_lat), .pre_cnt(pre_cnt),
    .per_cnt(per_cnt)
);

// File: tb/pwm8_gen_tb.sv
`timescale 1ns/1ps
module pwm8_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b1;
    logic       wr_duty = 1'b0;
    logic       wr_pre = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       run_en = 1'b0;
    logic       pin_sel = 1'b1;
    logic       gpio_bit = 1'b0;
    logic       pwm_pin;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pwm8_gen #(.W(8)) dut_i (
        .clk(clk), .rst(rst), .tick_en(tick_en), .wr_duty(wr_duty),
        .wr_pre(wr_pre), .wr_data(wr_data), .run_en(run_en),
        .pin_sel(pin_sel), .gpio_bit(gpio_bit), .pwm_pin(pwm_pin)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_reg(input bit duty, input logic [7:0] val);
        @(negedge clk);
        wr_data = val;
        if (duty) wr_duty = 1'b1; else wr_pre = 1'b1;
        @(negedge clk);
        wr_duty = 1'b0;
        wr_pre  = 1'b0;
    endtask

    // Samples len cycles; optional duty write after sample wr_at.
    task automatic measure(input int len, input int exp_hi, input string req,
                           input int wr_at, input logic [7:0] wr_val);
        int hi = 0;
        int rises = 0;
        logic first = 1'b0;
        logic prev = 1'b0;
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            wr_duty = 1'b0;
            if (k == 0) first = pwm_pin;
            else if (!prev && pwm_pin) rises++;
            prev = pwm_pin;
            hi += int'(pwm_pin);
            if (k == wr_at) begin
                wr_data = wr_val;
                wr_duty = 1'b1;
            end
        end
        check(hi == exp_hi, {req, " high count"}, hi, exp_hi);
        check(rises == 0 && (exp_hi == 0 || first), {req, " pulse shape"}, rises, 0);
    endtask

    task automatic hold_check(input int len, input logic lvl, input string req);
        int bad = 0;
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            if (pwm_pin !== lvl) bad++;
        end
        check(bad == 0, req, bad, 0);
    endtask

    initial begin
        int on_n = 0;
        int on_m = 0;
        int ns[6] = '{0, 1, 2, 128, 254, 255};
        int ms[2] = '{0, 2};
        repeat (3) @(negedge clk);
        check(pwm_pin == 1'b0, "R1 pin low in reset", int'(pwm_pin), 0);
        rst = 1'b0;
        @(negedge clk);
        check(pwm_pin == 1'b0, "R1 pin low after reset", int'(pwm_pin), 0);

        // Sweep: replay period, new period with a mid write, then the staged value.
        foreach (ms[mi]) begin
            foreach (ns[ni]) begin
                int n = ns[ni];
                int m = ms[mi];
                int x = 255 - n;
                @(negedge clk); run_en = 1'b0;
                repeat (2) @(negedge clk);
                write_reg(1'b1, 8'(n));
                write_reg(1'b0, 8'(m));
                run_en = 1'b1;
                measure(255 * (on_m + 1), on_n * (on_m + 1), "R7 replay period", -1, 8'h00);
                measure(255 * (m + 1), n * (m + 1), "R3 R4 new period", 10, 8'(x));
                measure(255 * (m + 1), x * (m + 1), "R2 R5 staged period", -1, 8'h00);
                on_n = x;
                on_m = m;
            end
        end

        // R8: routing
        @(negedge clk); pin_sel = 1'b0; gpio_bit = 1'b1;
        @(negedge clk);
        check(pwm_pin == 1'b1, "R8 gpio high", int'(pwm_pin), 1);
        gpio_bit = 1'b0;
        @(negedge clk);
        check(pwm_pin == 1'b0, "R8 gpio low", int'(pwm_pin), 0);
        pin_sel = 1'b1;

        // R2: held tick enable freezes the counters
        @(negedge clk); run_en = 1'b0;
        repeat (2) @(negedge clk);
        write_reg(1'b1, 8'd128);
        write_reg(1'b0, 8'd0);
        run_en = 1'b1;
        measure(255 * (on_m + 1), on_n * (on_m + 1), "R7 replay before tick test", -1, 8'h00);
        measure(3, 3, "R3 start of period", -1, 8'h00);
        tick_en = 1'b0;
        hold_check(40, 1'b1, "R2 no tick keeps level");
        tick_en = 1'b1;
        measure(252, 125, "R2 resumed period rest", -1, 8'h00);

        // R6: freeze high, then R7 replay after a partial period
        measure(5, 5, "R3 before high stop", -1, 8'h00);
        run_en = 1'b0;
        hold_check(20, 1'b1, "R6 frozen high");
        write_reg(1'b1, 8'd10);
        run_en = 1'b1;
        measure(255, 128, "R7 replay after stop", -1, 8'h00);
        measure(255, 10, "R7 written while stopped", -1, 8'h00);
        measure(200, 10, "R3 before low stop", -1, 8'h00);
        run_en = 1'b0;
        hold_check(20, 1'b0, "R6 frozen low");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule